// File: doc/BRIEF.md
# USB Endpoint Interrupt Event Generator

This block sits beside a USB serial interface engine. It turns the engine's per-transaction status pulses into one interrupt request for each of two endpoints. Endpoint 0 is the control endpoint and endpoint 1 is a non-control endpoint. Every cycle the engine presents, for each endpoint, a six-bit vector of single-cycle event pulses. It also presents a data-valid flag for the current OUT payload and the endpoint's four-bit mode code.

Each endpoint has its own set of trigger events. Any trigger sets a sticky pending flag, and firmware clears that flag with a one-cycle acknowledge pulse. The request line is the pending flag gated by that endpoint's bit in an interrupt-enable register. Firmware reads and writes this register through a simple register port.

Event vector bits, used by both endpoints:

| Bit | Event |
|-----|-------|
| 0 | The host wrote data into the endpoint FIFO |
| 1 | NAK or STALL sent in answer to a host IN |
| 2 | NAK or STALL sent in answer to a host OUT |
| 3 | ACK received after an IN |
| 4 | The endpoint was armed to accept SETUP |
| 5 | A zero-length status packet was sent |

Top module: `ep_irq_gen`

## Requirements
- R1: After reset, `irq_req` is 0, both enable bits are 0, both pending flags are clear, and `reg_rdata` is 0.
- R2: The enable register lives at address 0x21. Bit 0 enables the endpoint 0 request and bit 1 enables the endpoint 1 request. A write with `reg_we` to any other address has no effect. `reg_rdata` shows `{6'b0, enables}` one cycle after 0x21 is on `reg_addr`; for any other address it shows 0. Bits 7:2 always read 0.
- R3: On endpoint 0, a data-written event (bit 0) sets pending when `ep0_dvalid` is 1. It also sets pending when the mode is an ACK-OUT code, 4'h9 or 4'hB, whatever the data validity. In any other mode, invalid data sets nothing.
- R4: On endpoint 0, each of the events in bits 1 through 5 sets pending on its own.
- R5: On endpoint 1, a data-written event follows the same validity and ACK-OUT rule as in R3. The IN and OUT NAK/STALL events (bits 1 and 2) also set pending.
- R6: On endpoint 1, events in bits 3, 4 and 5 have no effect.
- R7: A pending flag stays set until its `irq_ack` bit pulses. If a trigger and an acknowledge for the same endpoint arrive in the same cycle, the flag stays set.
- R8: `irq_req[i]` equals pending[i] AND enable[i], registered. It rises in the cycle after the triggering event or the enabling write. Clearing an enable bit masks the request but keeps the pending flag. Events on one endpoint never affect the other endpoint.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address, used for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| ep0_evt | input | 6 | Endpoint 0 event pulses |
| ep0_dvalid | input | 1 | Endpoint 0 OUT data passed its checks |
| ep0_mode | input | 4 | Endpoint 0 mode code |
| ep1_evt | input | 6 | Endpoint 1 event pulses |
| ep1_dvalid | input | 1 | Endpoint 1 OUT data passed its checks |
| ep1_mode | input | 4 | Endpoint 1 mode code |
| irq_ack | input | 2 | Per-endpoint pending clear pulse |
| irq_req | output | 2 | Per-endpoint interrupt request |

## Verification
Every result is due exactly one clock edge after its cause:
- A trigger, acknowledge or enable write shows on `irq_req` after the next rising edge.
- The read value for the address presented shows on `reg_rdata` after the next rising edge.

The bench drives inputs 2 ns after a rising edge. Its behavioural model updates on that same next edge, and the bench compares both outputs 2 ns after it. That sampling point is one full register stage after the stimulus, in every cycle.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  localparam int NUM_EP = 2;
  localparam int EVT_W  = 6;
  localparam int MODE_W = 4;

  localparam int EV_DATA    = 0;
  localparam int EV_NAK_IN  = 1;
  localparam int EV_NAK_OUT = 2;
  localparam int EV_ACK_IN  = 3;
  localparam int EV_SETUP   = 4;
  localparam int EV_ZLP     = 5;

  localparam logic [MODE_W-1:0] MODE_ACKOUT    = 4'h9;
  localparam logic [MODE_W-1:0] MODE_ACKOUT_ST = 4'hB;

  // Events that an endpoint honours: the control endpoint takes all six,
  // other endpoints take only data and the two NAK/STALL events.
  function automatic logic [EVT_W-1:0] trig_mask(input int ep);
    logic [EVT_W-1:0] m;
    m = '0;
    m[EV_DATA]    = 1'b1;
    m[EV_NAK_IN]  = 1'b1;
    m[EV_NAK_OUT] = 1'b1;
    if (ep == 0) begin
      m[EV_ACK_IN] = 1'b1;
      m[EV_SETUP]  = 1'b1;
      m[EV_ZLP]    = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ep_irq_trig.sv
module ep_irq_trig
  import ep_irq_pkg::*;
#(
  parameter int EP_IDX = 0
) (
  input  logic [EVT_W-1:0]  evt,
  input  logic              dvalid,
  input  logic [MODE_W-1:0] mode,
  output logic              hit
);
  localparam logic [EVT_W-1:0] MASK  = trig_mask(EP_IDX);
  localparam logic [EVT_W-1:0] OTHER = MASK & ~(EVT_W'(1) << EV_DATA);

  logic ackout;
  logic data_hit;

  always_comb begin
    ackout   = (mode == MODE_ACKOUT) || (mode == MODE_ACKOUT_ST);
    data_hit = evt[EV_DATA] && (dvalid || ackout);
    hit      = data_hit || (|(evt & OTHER));
  end
endmodule

// File: rtl/ep_irq_pend.sv
module ep_irq_pend (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic ack,
  input  logic en_d,
  output logic pend_q,
  output logic irq_q
);
  logic pend_d;

  always_comb pend_d = hit | (pend_q & ~ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= pend_d & en_d;
    end
  end
endmodule

// File: rtl/ep_irq_csr.sv
module ep_irq_csr #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_EP   = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_EP-1:0] en_d,
  output logic [NUM_EP-1:0] en_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic sel;

  always_comb begin
    sel  = (addr == REG_ADDR);
    en_d = (we && sel) ? wdata[NUM_EP-1:0] : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      rdata_q <= sel ? DATA_W'(en_d) : '0;
    end
  end
endmodule

// File: rtl/ep_irq_gen.sv
module ep_irq_gen
  import ep_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  ep0_evt,
  input  logic              ep0_dvalid,
  input  logic [MODE_W-1:0] ep0_mode,
  input  logic [EVT_W-1:0]  ep1_evt,
  input  logic              ep1_dvalid,
  input  logic [MODE_W-1:0] ep1_mode,
  input  logic [NUM_EP-1:0] irq_ack,
  output logic [NUM_EP-1:0] irq_req
);
  logic [EVT_W-1:0]  evt_a    [NUM_EP];
  logic [MODE_W-1:0] mode_a   [NUM_EP];
  logic [NUM_EP-1:0] dvalid_a;
  logic [NUM_EP-1:0] hit;
  logic [NUM_EP-1:0] pend_q;
  logic [NUM_EP-1:0] en_d;
  logic [NUM_EP-1:0] en_q;

  always_comb begin
    evt_a[0]    = ep0_evt;
    evt_a[1]    = ep1_evt;
    mode_a[0]   = ep0_mode;
    mode_a[1]   = ep1_mode;
    dvalid_a[0] = ep0_dvalid;
    dvalid_a[1] = ep1_dvalid;
  end

  ep_irq_csr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_EP(NUM_EP), .REG_ADDR(REG_ADDR)
  ) csr_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .en_d(en_d), .en_q(en_q), .rdata_q(reg_rdata)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    ep_irq_trig #(.EP_IDX(i)) trig_i (
      .evt(evt_a[i]), .dvalid(dvalid_a[i]), .mode(mode_a[i]), .hit(hit[i])
    );
    ep_irq_pend pend_i (
      .clk(clk), .rst(rst), .hit(hit[i]), .ack(irq_ack[i]),
      .en_d(en_d[i]), .pend_q(pend_q[i]), .irq_q(irq_req[i])
    );
  end
endmodule

// File: rtl/ep_irq_chk.sv
module ep_irq_chk
  import ep_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NUM_EP-1:0] irq_req,
  input logic [NUM_EP-1:0] irq_ack,
  input logic [NUM_EP-1:0] hit,
  input logic [NUM_EP-1:0] pend_q,
  input logic [NUM_EP-1:0] en_q,
  input logic [EVT_W-1:0]  ep0_evt,
  input logic              ep0_dvalid,
  input logic [MODE_W-1:0] ep0_mode,
  input logic [EVT_W-1:0]  ep1_evt
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (irq_req == '0 && reg_rdata == '0));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst) reg_rdata[DATA_W-1:NUM_EP] == '0);

  // R3
  ep0_bad_data_chk: assert property (@(posedge clk) disable iff (rst)
    (ep0_evt == 6'b000001 && !ep0_dvalid && ep0_mode != MODE_ACKOUT &&
     ep0_mode != MODE_ACKOUT_ST && !pend_q[0]) |=> !pend_q[0]);

  // R6
  ep1_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (ep1_evt[2:0] == 3'b000 && !pend_q[1]) |=> !pend_q[1]);

  // R7
  ep0_set_chk: assert property (@(posedge clk) disable iff (rst) hit[0] |=> pend_q[0]);

  // R7
  ep1_set_chk: assert property (@(posedge clk) disable iff (rst) hit[1] |=> pend_q[1]);

  // R7
  ep0_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack[0] && !hit[0]) |=> !pend_q[0]);

  // R8
  req_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req == (pend_q & en_q));
endmodule

bind ep_irq_gen ep_irq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .reg_rdata(reg_rdata), .irq_req(irq_req),
  .irq_ack(irq_ack), .hit(hit), .pend_q(pend_q), .en_q(en_q),
  .ep0_evt(ep0_evt), .ep0_dvalid(ep0_dvalid), .ep0_mode(ep0_mode),
  .ep1_evt(ep1_evt)
);

// File: tb/ep_irq_gen_tb_top.sv
module ep_irq_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [5:0] ep0_evt = '0;
  logic       ep0_dvalid = 1'b0;
  logic [3:0] ep0_mode = '0;
  logic [5:0] ep1_evt = '0;
  logic       ep1_dvalid = 1'b0;
  logic [3:0] ep1_mode = '0;
  logic [1:0] irq_ack = '0;
  logic [1:0] irq_req;

  int    checks = 0;
  int    bad = 0;
  bit    done = 0;
  string phase = "R1";

  // reference state
  bit       m_pend [2];
  bit [1:0] m_en;
  bit [1:0] m_irq;
  bit [7:0] m_rd;

  always #5 clk = ~clk;

  ep_irq_gen dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ep0_evt(ep0_evt), .ep0_dvalid(ep0_dvalid), .ep0_mode(ep0_mode),
    .ep1_evt(ep1_evt), .ep1_dvalid(ep1_dvalid), .ep1_mode(ep1_mode),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  function automatic bit fires(int ep, bit [5:0] ev, bit dv, bit [3:0] md);
    bit data_ok;
    data_ok = ev[0] && (dv || md == 4'h9 || md == 4'hB);
    if (data_ok || ev[1] || ev[2]) return 1;
    if (ep == 0 && (ev[3] || ev[4] || ev[5])) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pend[0] = 0; m_pend[1] = 0; m_en = 0; m_irq = 0; m_rd = 0;
    end else begin
      bit f0, f1;
      f0 = fires(0, ep0_evt, ep0_dvalid, ep0_mode);
      f1 = fires(1, ep1_evt, ep1_dvalid, ep1_mode);
      if (f0) m_pend[0] = 1; else if (irq_ack[0]) m_pend[0] = 0;
      if (f1) m_pend[1] = 1; else if (irq_ack[1]) m_pend[1] = 0;
      if (reg_we && reg_addr == 8'h21) m_en = reg_wdata[1:0];
      m_irq = {m_pend[1] & m_en[1], m_pend[0] & m_en[0]};
      m_rd  = (reg_addr == 8'h21) ? {6'b0, m_en} : 8'h00;
    end
  end

  task automatic compare();
    checks++;
    if (irq_req !== m_irq) begin
      bad++;
      $display("FAIL %s irq_req act=%b exp=%b t=%0t", phase, irq_req, m_irq, $time);
    end
    checks++;
    if (reg_rdata !== m_rd) begin
      bad++;
      $display("FAIL %s reg_rdata act=%h exp=%h t=%0t", phase, reg_rdata, m_rd, $time);
    end
  endtask

  // one clock: wait for edge, sample 2 ns later, clear pulses
  task automatic tick();
    @(posedge clk);
    #2;
    compare();
    reg_we = 0; ep0_evt = '0; ep1_evt = '0; irq_ack = '0;
  endtask

  task automatic wr_en(bit [7:0] a, bit [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_addr = 8'h21;
  endtask

  task automatic ep0(bit [5:0] ev, bit dv, bit [3:0] md);
    ep0_evt = ev; ep0_dvalid = dv; ep0_mode = md;
    tick();
    tick();
    irq_ack = 2'b11;
    tick();
  endtask

  task automatic ep1(bit [5:0] ev, bit dv, bit [3:0] md);
    ep1_evt = ev; ep1_dvalid = dv; ep1_mode = md;
    tick();
    tick();
    irq_ack = 2'b11;
    tick();
  endtask

  initial begin
    // R1 reset state
    phase = "R1";
    reg_addr = 8'h21;
    @(posedge clk); @(posedge clk); #2;
    compare();
    rst = 0;
    tick();
    tick();

    // R2 enable register
    phase = "R2";
    wr_en(8'h21, 8'h03); tick();
    wr_en(8'h20, 8'h00); tick();
    reg_addr = 8'h20; tick(); reg_addr = 8'h21; tick();
    wr_en(8'h21, 8'hFE); tick();
    wr_en(8'h21, 8'hFD); tick();
    wr_en(8'h21, 8'h03); tick();

    // R3 endpoint 0 data rule
    phase = "R3";
    ep0(6'b000001, 1, 4'h0);
    ep0(6'b000001, 0, 4'h0);
    ep0(6'b000001, 0, 4'h9);
    ep0(6'b000001, 0, 4'hB);
    ep0(6'b000001, 0, 4'hA);
    ep0(6'b000001, 0, 4'h8);

    // R4 other endpoint 0 triggers
    phase = "R4";
    for (int b = 1; b < 6; b++) ep0(6'(1 << b), 0, 4'h0);

    // R5 endpoint 1 triggers
    phase = "R5";
    ep1(6'b000001, 1, 4'h0);
    ep1(6'b000001, 0, 4'h0);
    ep1(6'b000001, 0, 4'h9);
    ep1(6'b000001, 0, 4'hB);
    ep1(6'b000010, 0, 4'h0);
    ep1(6'b000100, 0, 4'h0);

    // R6 endpoint 1 ignores bits 3..5
    phase = "R6";
    ep1(6'b001000, 1, 4'h9);
    ep1(6'b010000, 1, 4'h0);
    ep1(6'b100000, 1, 4'h0);
    ep1(6'b111000, 1, 4'h0);

    // R7 sticky and collision
    phase = "R7";
    ep0_evt = 6'b000010; tick();
    tick(); tick();
    ep0_evt = 6'b000100; irq_ack = 2'b01; tick();
    tick();
    irq_ack = 2'b01; tick();
    tick();
    ep1_evt = 6'b000010; irq_ack = 2'b10; tick();
    irq_ack = 2'b10; tick();
    tick();

    // R8 masking and independence
    phase = "R8";
    wr_en(8'h21, 8'h00); tick();
    ep0_evt = 6'b010000; tick(); tick();
    wr_en(8'h21, 8'h01); tick();
    wr_en(8'h21, 8'h02); tick();
    ep1_evt = 6'b000100; tick(); tick();
    wr_en(8'h21, 8'h03); tick();
    irq_ack = 2'b01; tick();
    irq_ack = 2'b10; tick();

    // R8 mixed traffic
    for (int n = 0; n < 400; n++) begin
      ep0_evt    = 6'($urandom) & 6'($urandom);
      ep1_evt    = 6'($urandom) & 6'($urandom);
      ep0_dvalid = 1'($urandom);
      ep1_dvalid = 1'($urandom);
      ep0_mode   = 4'($urandom);
      ep1_mode   = 4'($urandom);
      irq_ack    = 2'($urandom);
      reg_we     = ($urandom % 8) == 0;
      reg_addr   = ($urandom % 2) ? 8'h21 : 8'($urandom);
      reg_wdata  = 8'($urandom);
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule